// File: doc/BRIEF.md
# Caption Serial Output Buffer

This block sits between a caption-extraction front end and a host microcontroller. Each time the front end recovers a 16-bit caption word, it pulses a load strobe and the word is captured into a holding register. The host then reads the word serially. It pulls a chip-select line low, supplies its own shift clock, and samples an open-drain data line. The block brings the host's chip-select and shift clock into the system clock domain through two-flop synchronizers and detects their edges there.

The least significant bit appears on the line when chip-select falls. Each later falling edge of the shift clock advances the line by one bit. While chip-select is low the holding register is frozen, so the host must raise chip-select after every read.

In the two recorder modes the block also supports polling. A completed read marks the current frame as consumed. A further read before the next load returns a word of zeros, which tells the host that no fresh data has arrived. In the two television modes a repeated read returns the held word again.

Top module: `cc_serial_outbuf`

## Requirements
- R1: After reset the data line is released, and a read made before any load returns the word 16'h0000.
- R2: `sdo_pull` is 0 whenever the synchronized chip-select is high, that is from 3 clock cycles after `host_cs_n` rises until 3 cycles after it next falls.
- R3: A read outputs the held word least significant bit first. Bit 0 is presented 3 cycles after `host_cs_n` falls, and bit k is presented 3 cycles after the k-th falling edge of `host_sck`. A bit value of 0 drives `sdo_pull`=1, and a bit value of 1 gives `sdo_pull`=0.
- R4: After the 16th falling edge of `host_sck` within one read, the line is released (`sdo_pull`=0) until chip-select rises.
- R5: A `cap_load` pulse while chip-select is high replaces the held word and clears the frame-consumed state. A read that is not preceded by a new load outputs the previous word, apart from the case in R7.
- R6: A `cap_load` pulse while chip-select is low is discarded. The read in progress and every later read output the word held before that pulse.
- R7: In modes 2'b00 and 2'b01 (the recorder modes), a read that follows a completed 16-bit read with no accepted load in between outputs 16 zero bits.
- R8: In modes 2'b10 and 2'b11 (the television modes), repeated reads without a new load all output the held word.
- R9: A read that ends (chip-select rises) before 16 falling edges of `host_sck` does not mark the frame consumed. The next read still returns the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_word | input | 16 | Newly extracted caption word |
| cap_load | input | 1 | One-cycle strobe that captures `cap_word` |
| mode | input | 2 | 00/01 recorder modes (zero on repeat read), 10/11 television modes |
| host_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| host_sck | input | 1 | Host shift clock, asynchronous; falling edges advance the bit |
| sdo_pull | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |

## Verification
The bench targets three situations.

- A load strobe that arrives while a read is in progress. A design that lets that load through would corrupt the word mid-shift, or would hand the discarded word to the next read.
- Repeated reads in each mode family. A design that gets the mode split wrong would either starve the television host of data or never signal an empty frame to a polling recorder host.
- A read aborted after five bits. If the design counts that read as complete, the following read wrongly returns zeros.

The bench also probes the 17th shift-clock edge and the chip-select-high interval, where a careless shifter would leave the line pulled low.

// File: rtl/cc_serial_outbuf.sv
module cc_serial_outbuf #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              cap_load,
  input  logic [1:0]        mode,
  input  logic              host_cs_n,
  input  logic              host_sck,
  output logic              sdo_pull
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [2:0]        cs_q, sck_q;
  logic              cs_s2, cs_fall, sck_fall;
  logic [WORD_W-1:0] held, shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              active, read_done, zero_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '1;
    end else begin
      cs_q  <= {cs_q[1:0], host_cs_n};
      sck_q <= {sck_q[1:0], host_sck};
    end
  end

  assign cs_s2    = cs_q[1];
  assign cs_fall  = cs_q[2] & ~cs_q[1];
  assign sck_fall = sck_q[2] & ~sck_q[1];
  assign zero_now = ~mode[1] & read_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= '0;
      shreg     <= '1;
      bit_cnt   <= '0;
      active    <= 1'b0;
      read_done <= 1'b0;
    end else begin
      if (cap_load && cs_s2) begin
        held      <= cap_word;
        read_done <= 1'b0;
      end
      if (cs_s2) begin
        active <= 1'b0;
      end else if (cs_fall) begin
        active  <= 1'b1;
        shreg   <= zero_now ? '0 : held;
        bit_cnt <= '0;
      end else if (active && sck_fall) begin
        shreg <= {1'b1, shreg[WORD_W-1:1]};
        if (bit_cnt != CNT_W'(WORD_W)) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(WORD_W - 1)) read_done <= 1'b1;
      end
    end
  end

  assign sdo_pull = active & ~shreg[0];
endmodule

module cc_serial_outbuf_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_cs_n,
  input logic              cap_load,
  input logic [1:0]        mode,
  input logic              sdo_pull,
  input logic              read_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              sck_fall,
  input logic              cs_fall,
  input logic              cs_s2,
  input logic [WORD_W-1:0] shreg
);
  // R2
  cs_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs_n && $past(host_cs_n) && $past(host_cs_n, 2) && $past(host_cs_n, 3)) |-> !sdo_pull);

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_done) |-> $past(cap_load));

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_done) |-> ($past(bit_cnt) == CNT_W'(WORD_W - 1) && $past(sck_fall)));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_pull) |-> $past(sck_fall || cs_fall || cs_s2));

  // R7
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !mode[1] && read_done) |=> (shreg == '0));
endmodule

bind cc_serial_outbuf cc_serial_outbuf_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .cap_load(cap_load), .mode(mode),
  .sdo_pull(sdo_pull), .read_done(read_done), .bit_cnt(bit_cnt), .sck_fall(sck_fall),
  .cs_fall(cs_fall), .cs_s2(cs_s2), .shreg(shreg)
);

// File: tb/tb_cc_serial_outbuf.sv
module tb_cc_serial_outbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cap_word = '0;
  logic        cap_load = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        host_cs_n = 1'b1;
  logic        host_sck = 1'b1;
  logic        sdo_pull;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cc_serial_outbuf dut (.*);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk);
    cap_word = w;
    cap_load = 1'b1;
    @(negedge clk);
    cap_load = 1'b0;
    wait_n(2);
  endtask

  task automatic do_read(input string tag, input logic [15:0] exp, input int nb,
                         input bit mid, input logic [15:0] mw);
    logic [15:0] got;
    logic [15:0] mask;
    got = '1;
    mask = (nb >= 16) ? 16'hFFFF : ((16'h1 << nb) - 16'h1);
    @(negedge clk);
    host_cs_n = 1'b0;
    wait_n(5);
    if (mid) begin
      cap_word = mw;
      cap_load = 1'b1;
      @(negedge clk);
      cap_load = 1'b0;
    end
    wait_n(15);
    for (int i = 0; i < nb; i++) begin
      got[i] = ~sdo_pull;
      host_sck = 1'b0;
      wait_n(10);
      host_sck = 1'b1;
      wait_n(10);
    end
    check(tag, got & mask, exp & mask);
    if (nb >= 16) begin
      host_sck = 1'b0;
      wait_n(10);
      host_sck = 1'b1;
      wait_n(10);
      check("R4 released after 16 bits", {15'b0, sdo_pull}, 16'h0);
    end
    host_cs_n = 1'b1;
    wait_n(10);
    check("R2 released with CS high", {15'b0, sdo_pull}, 16'h0);
  endtask

  task automatic t_reset;
    wait_n(5);
    check("R1 line released in reset", {15'b0, sdo_pull}, 16'h0);
    rst_n = 1'b1;
    wait_n(5);
    check("R1 line released after reset", {15'b0, sdo_pull}, 16'h0);
    mode = 2'b10;
    do_read("R1 read before load", 16'h0000, 16, 1'b0, 16'h0);
  endtask

  task automatic t_basic;
    mode = 2'b10;
    load(16'hA5C3);
    do_read("R3 LSB-first word", 16'hA5C3, 16, 1'b0, 16'h0);
    do_read("R8 repeat read mode 10", 16'hA5C3, 16, 1'b0, 16'h0);
    mode = 2'b11;
    do_read("R8 repeat read mode 11", 16'hA5C3, 16, 1'b0, 16'h0);
    load(16'h1234);
    wait_n(10);
    check("R2 bit0=0 but CS high", {15'b0, sdo_pull}, 16'h0);
    do_read("R5 new word replaces old", 16'h1234, 16, 1'b0, 16'h0);
  endtask

  task automatic t_poll;
    mode = 2'b00;
    load(16'h8001);
    do_read("R5 first read mode 00", 16'h8001, 16, 1'b0, 16'h0);
    do_read("R7 second read mode 00 zeros", 16'h0000, 16, 1'b0, 16'h0);
    mode = 2'b01;
    load(16'h7E10);
    do_read("R5 first read mode 01", 16'h7E10, 16, 1'b0, 16'h0);
    do_read("R7 second read mode 01 zeros", 16'h0000, 16, 1'b0, 16'h0);
    load(16'hC0DE);
    do_read("R5 load clears consumed state", 16'hC0DE, 16, 1'b0, 16'h0);
  endtask

  task automatic t_partial;
    mode = 2'b00;
    load(16'h0F0F);
    do_read("R9 partial read bits", 16'h0F0F, 5, 1'b0, 16'h0);
    do_read("R9 full read after partial", 16'h0F0F, 16, 1'b0, 16'h0);
    do_read("R7 zeros after full read", 16'h0000, 16, 1'b0, 16'h0);
  endtask

  task automatic t_blocked;
    mode = 2'b10;
    load(16'h3C3C);
    do_read("R6 load during read ignored", 16'h3C3C, 16, 1'b1, 16'hFFFF);
    do_read("R6 discarded word never appears", 16'h3C3C, 16, 1'b0, 16'h0);
    mode = 2'b00;
    load(16'h5AA5);
    do_read("R6 held word in mode 00", 16'h5AA5, 16, 1'b1, 16'h0000);
    do_read("R7 zeros, blocked load did not clear", 16'h0000, 16, 1'b0, 16'h0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_poll();
    t_partial();
    t_blocked();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired (R1..R9 incomplete): got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule